// File: doc/BRIEF.md
# PLL Configuration Word Encoder for a Serial Display Bridge

This block turns two integers, the wanted bit rate per data lane in kbps and the PLL reference clock in kHz, into the 16-bit PLL setting word of a parallel-to-serial display bridge. It also returns the PLL rate that the word actually produces and the 6-bit low-power clock divider field that goes with that rate. A start pulse latches the operands. The block then runs a short sequential search for the input divider. After that, a shared bit-serial unsigned divider carries out the multiplier ceiling, the achieved rate and the low-power divider ceiling, one after the other. A one-cycle done strobe marks the moment the registered results are updated.

The same engine has a decode mode. In that mode a packed word supplied at the port is turned back into a PLL rate and its low-power divider field, which lets firmware or a neighbouring block check a word it already holds. No result changes between one done strobe and the next accepted start.

Top module: `pll_cfg_encoder`

## Requirements
- R1: In encode mode the divider field word_o[12:8] equals min(31, max(1, floor(ref/5000))). This is the last value d, counting up from 1, for which ref/(d+1) stayed at or above 5000 kHz, capped at 31.
- R2: The multiplier is M = ceil(rate*d/ref). When M > 255, word_o[7:0] is 255 and ovf_o is 1. Otherwise word_o[7:0] = M and ovf_o is 0.
- R3: The band code in word_o[15:14] comes from the achieved rate A = ref*m/d, where m is the multiplier field and the division truncates. The code is 3 when A >= 501000, 2 when A >= 251000, 1 when A >= 126000, and 0 otherwise.
- R4: In encode mode word_o[13] is 0.
- R5: rate_o = ref*m'/d' with truncating division. Here m' and d' are the multiplier and divider fields of the result word, with a field of 0 read as 1.
- R6: lp_o = (ceil(rate_o/80000) - 1) mod 64.
- R7: In decode mode (decode_i high at start) word_o repeats word_i, ovf_o is 0, and rate_o and lp_o follow R5 and R6 using the fields word_i[7:0] and word_i[12:8].
- R8: done_o is high for exactly one cycle per accepted start. A start while busy_o is high is ignored, and the result of the run in progress is unchanged.
- R9: Between a done strobe and the next accepted start, word_o, rate_o, lp_o and ovf_o hold their values whatever the data inputs do.
- R10: After reset busy_o, done_o, ovf_o, word_o, rate_o and lp_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse; latches the operands when idle |
| decode_i | input | 1 | 1: decode word_i; 0: encode from the rates |
| lane_kbps_i | input | 32 | Wanted per-lane bit rate in kbps |
| ref_khz_i | input | 32 | PLL reference clock in kHz (must be nonzero) |
| word_i | input | 16 | Packed word to decode |
| busy_o | output | 1 | A computation is running |
| done_o | output | 1 | One-cycle strobe; results updated |
| word_o | output | 16 | Packed PLL word {band, 0, divider, multiplier} |
| rate_o | output | 40 | PLL rate in kbps produced by word_o |
| lp_o | output | 6 | Low-power clock divider field |
| ovf_o | output | 1 | Multiplier saturated at 255 |

## Verification
The hardest case to reach is the one where the achieved rate used for the band code differs from the decoded rate used for the low-power divider. This only happens when the requested rate is zero, so the multiplier field is 0. Random stimulus almost never produces it, so directed runs with a zero lane rate cover it, together with runs whose achieved rates land exactly on each band threshold and a large reference whose low-power count wraps past 64. A start pulse injected halfway through a run, with different operands, exercises the ignore rule, and the check confirms that the first run's result comes out intact.

// File: rtl/pllcfg_pkg.sv
package pllcfg_pkg;
  localparam int MUL_W  = 8;
  localparam int DIVF_W = 5;
  localparam int BAND_W = 2;
  localparam int WORD_W = 16;
  localparam int LPF_W  = 6;
  localparam int MUL_MAX = (1 << MUL_W) - 1;

  localparam longint BAND3_KBPS = 501000;
  localparam longint BAND2_KBPS = 251000;
  localparam longint BAND1_KBPS = 126000;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SRCH,
    ST_MUL,
    ST_RATE,
    ST_LP
  } eng_state_t;
endpackage

// File: rtl/pllcfg_seq_udiv.sv
module pllcfg_seq_udiv #(
  parameter int NW = 40,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go_i,
  input  logic [NW-1:0] num_i,
  input  logic [DW-1:0] den_i,
  output logic          fin_o,
  output logic [NW-1:0] quo_o,
  output logic [DW-1:0] rem_o
);
  localparam int CW = $clog2(NW + 1);

  logic [NW-1:0] q_r;
  logic [DW-1:0] r_r;
  logic [DW-1:0] den_r;
  logic [CW-1:0] cnt_r;
  logic          run_r;

  logic [DW:0] trial;
  logic        take;
  logic [DW:0] sub;

  always_comb begin
    trial = {r_r, q_r[NW-1]};
    take  = trial >= {1'b0, den_r};
    sub   = trial - {1'b0, den_r};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_r   <= '0;
      r_r   <= '0;
      den_r <= '0;
      cnt_r <= '0;
      run_r <= 1'b0;
      fin_o <= 1'b0;
    end else begin
      fin_o <= 1'b0;
      if (go_i) begin
        q_r   <= num_i;
        r_r   <= '0;
        den_r <= den_i;
        cnt_r <= CW'(NW);
        run_r <= 1'b1;
      end else if (run_r) begin
        q_r   <= {q_r[NW-2:0], take};
        r_r   <= take ? sub[DW-1:0] : trial[DW-1:0];
        cnt_r <= cnt_r - 1'b1;
        if (cnt_r == CW'(1)) begin
          run_r <= 1'b0;
          fin_o <= 1'b1;
        end
      end
    end
  end

  assign quo_o = q_r;
  assign rem_o = r_r;

  // R2
  rem_below_den_chk: assert property (@(posedge clk) disable iff (rst)
    (fin_o && den_r != '0) |-> (rem_o < den_r));
endmodule

// File: rtl/pllcfg_band_sel.sv
module pllcfg_band_sel
  import pllcfg_pkg::*;
#(
  parameter int NW = 40
) (
  input  logic [NW-1:0]     rate_i,
  output logic [BAND_W-1:0] band_o
);
  localparam logic [NW-1:0] T3 = NW'(BAND3_KBPS);
  localparam logic [NW-1:0] T2 = NW'(BAND2_KBPS);
  localparam logic [NW-1:0] T1 = NW'(BAND1_KBPS);

  always_comb begin
    if (rate_i >= T3)      band_o = 2'd3;
    else if (rate_i >= T2) band_o = 2'd2;
    else if (rate_i >= T1) band_o = 2'd1;
    else                   band_o = 2'd0;
  end
endmodule

// File: rtl/pll_cfg_encoder.sv
module pll_cfg_encoder
  import pllcfg_pkg::*;
#(
  parameter int RATE_W    = 32,
  parameter int FLOOR_KHZ = 5000,
  parameter int DIV_MAX   = 31,
  parameter int LP_KHZ    = 10000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              decode_i,
  input  logic [RATE_W-1:0] lane_kbps_i,
  input  logic [RATE_W-1:0] ref_khz_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [WORD_W-1:0] word_o,
  output logic [RATE_W+MUL_W-1:0] rate_o,
  output logic [LPF_W-1:0]  lp_o,
  output logic              ovf_o
);
  localparam int NW = RATE_W + MUL_W;
  localparam int LP_DEN = LP_KHZ * 8;

  eng_state_t          state_q;
  logic [RATE_W-1:0]   des_q, ref_q;
  logic [WORD_W-1:0]   win_q;
  logic                dec_q;
  logic [DIVF_W-1:0]   dv_q;
  logic [MUL_W-1:0]    ml_q;
  logic                ovf_q;
  logic [NW-1:0]       rate_q;

  logic                go_q;
  logic [NW-1:0]       num_q;
  logic [RATE_W-1:0]   den_q;
  logic                fin;
  logic [NW-1:0]       quo;
  logic [RATE_W-1:0]   rem;

  pllcfg_seq_udiv #(.NW(NW), .DW(RATE_W)) u_div (
    .clk(clk), .rst(rst), .go_i(go_q), .num_i(num_q), .den_i(den_q),
    .fin_o(fin), .quo_o(quo), .rem_o(rem)
  );

  // achieved rate for the band code: zero multiplier gives zero
  logic [NW-1:0]     ach_rate;
  logic [BAND_W-1:0] band;
  assign ach_rate = (ml_q == '0) ? '0 : rate_q;

  pllcfg_band_sel #(.NW(NW)) u_band (.rate_i(ach_rate), .band_o(band));

  // search step: keep growing while ref >= floor*(d+1)
  logic [RATE_W-1:0] step_floor;
  logic              srch_stop;
  assign step_floor = RATE_W'(FLOOR_KHZ * (int'(dv_q) + 1));
  assign srch_stop  = (int'(dv_q) >= DIV_MAX) || (ref_q < step_floor);

  // multiplier ceiling and saturation from divider result
  logic              rem_nz;
  logic              mul_ovf;
  logic [MUL_W-1:0]  mul_sat;
  logic [MUL_W-1:0]  mul_eff;
  assign rem_nz  = (rem != '0);
  assign mul_ovf = (|quo[NW-1:MUL_W]) || (quo[MUL_W-1:0] == MUL_W'(MUL_MAX) && rem_nz);
  assign mul_sat = mul_ovf ? MUL_W'(MUL_MAX) : (quo[MUL_W-1:0] + MUL_W'(rem_nz));
  assign mul_eff = (mul_sat == '0) ? MUL_W'(1) : mul_sat;

  // decode-mode field interpretation
  logic [MUL_W-1:0]  dec_ml;
  logic [DIVF_W-1:0] dec_dv;
  assign dec_ml = (word_i[MUL_W-1:0] == '0) ? MUL_W'(1) : word_i[MUL_W-1:0];
  assign dec_dv = (word_i[MUL_W+DIVF_W-1:MUL_W] == '0) ? DIVF_W'(1)
                                                       : word_i[MUL_W+DIVF_W-1:MUL_W];

  logic [LPF_W-1:0] lp_next;
  assign lp_next = quo[LPF_W-1:0] + LPF_W'(rem_nz) - LPF_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      des_q   <= '0;
      ref_q   <= '0;
      win_q   <= '0;
      dec_q   <= 1'b0;
      dv_q    <= '0;
      ml_q    <= '0;
      ovf_q   <= 1'b0;
      rate_q  <= '0;
      go_q    <= 1'b0;
      num_q   <= '0;
      den_q   <= '0;
      done_o  <= 1'b0;
      word_o  <= '0;
      rate_o  <= '0;
      lp_o    <= '0;
      ovf_o   <= 1'b0;
    end else begin
      go_q   <= 1'b0;
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            des_q <= lane_kbps_i;
            ref_q <= ref_khz_i;
            win_q <= word_i;
            dec_q <= decode_i;
            ovf_q <= 1'b0;
            if (decode_i) begin
              dv_q    <= dec_dv;
              ml_q    <= word_i[MUL_W-1:0];
              go_q    <= 1'b1;
              num_q   <= NW'(ref_khz_i) * NW'(dec_ml);
              den_q   <= RATE_W'(dec_dv);
              state_q <= ST_RATE;
            end else begin
              dv_q    <= DIVF_W'(1);
              state_q <= ST_SRCH;
            end
          end
        end
        ST_SRCH: begin
          if (srch_stop) begin
            go_q    <= 1'b1;
            num_q   <= NW'(des_q) * NW'(dv_q);
            den_q   <= ref_q;
            state_q <= ST_MUL;
          end else begin
            dv_q <= dv_q + 1'b1;
          end
        end
        ST_MUL: begin
          if (fin) begin
            ml_q    <= mul_sat;
            ovf_q   <= mul_ovf;
            go_q    <= 1'b1;
            num_q   <= NW'(ref_q) * NW'(mul_eff);
            den_q   <= RATE_W'(dv_q);
            state_q <= ST_RATE;
          end
        end
        ST_RATE: begin
          if (fin) begin
            rate_q  <= quo;
            go_q    <= 1'b1;
            num_q   <= quo;
            den_q   <= RATE_W'(LP_DEN);
            state_q <= ST_LP;
          end
        end
        ST_LP: begin
          if (fin) begin
            word_o  <= dec_q ? win_q : {band, 1'b0, dv_q, ml_q};
            rate_o  <= rate_q;
            lp_o    <= lp_next;
            ovf_o   <= ovf_q;
            done_o  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R2
  ovf_saturates_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_o |-> (word_o[MUL_W-1:0] == MUL_W'(MUL_MAX)));

  // R1
  div_field_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && !dec_q) |-> (word_o[MUL_W+DIVF_W-1:MUL_W] != '0));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !start_i) |=> ($stable(word_o) && $stable(rate_o) && $stable(lp_o) && $stable(ovf_o)));
endmodule

// File: tb/tb_pll_cfg_encoder.sv
module tb_pll_cfg_encoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic        decode_i = 1'b0;
  logic [31:0] lane_kbps_i = '0;
  logic [31:0] ref_khz_i = '0;
  logic [15:0] word_i = '0;
  logic        busy_o, done_o, ovf_o;
  logic [15:0] word_o;
  logic [39:0] rate_o;
  logic [5:0]  lp_o;

  int n_chk = 0;
  int n_fail = 0;

  longint e_word, e_rate, e_lp, e_ovf;

  pll_cfg_encoder dut (
    .clk(clk), .rst(rst), .start_i(start_i), .decode_i(decode_i),
    .lane_kbps_i(lane_kbps_i), .ref_khz_i(ref_khz_i), .word_i(word_i),
    .busy_o(busy_o), .done_o(done_o), .word_o(word_o), .rate_o(rate_o),
    .lp_o(lp_o), .ovf_o(ovf_o)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input longint got, input longint exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  task automatic lp_model(input longint r);
    e_rate = r;
    e_lp   = (((r + 79999) / 80000) - 1) & 63;
  endtask

  task automatic enc_model(input longint des, input longint rf);
    longint d, m, a, b;
    d = 1;
    while (rf / (d + 1) >= 5000 && d < 31) d++;
    m = (des * d + rf - 1) / rf;
    e_ovf = (m > 255) ? 1 : 0;
    if (m > 255) m = 255;
    a = rf * m / d;
    b = (a >= 501000) ? 3 : (a >= 251000) ? 2 : (a >= 126000) ? 1 : 0;
    e_word = (b << 14) | (d << 8) | m;
    lp_model(rf * ((m == 0) ? 1 : m) / d);
  endtask

  task automatic dec_model(input longint w, input longint rf);
    longint m, d;
    m = w & 255;
    d = (w >> 8) & 31;
    if (m == 0) m = 1;
    if (d == 0) d = 1;
    e_word = w;
    e_ovf  = 0;
    lp_model(rf * m / d);
  endtask

  task automatic launch(input bit dec, input longint des, input longint rf, input longint w);
    @(negedge clk);
    decode_i    = dec;
    lane_kbps_i = 32'(des);
    ref_khz_i   = 32'(rf);
    word_i      = 16'(w);
    start_i     = 1'b1;
    @(negedge clk);
    start_i     = 1'b0;
  endtask

  task automatic wait_done();
    int k;
    k = 0;
    while (done_o !== 1'b1 && k < 2000) begin
      @(negedge clk);
      k++;
    end
    if (k >= 2000) chk("R8 done timeout", 0, 1);
  endtask

  task automatic check_all(input string tag);
    chk({tag, " R4 word"}, longint'(word_o), e_word);
    chk({tag, " R5 rate"}, longint'(rate_o), e_rate);
    chk({tag, " R6 lp"}, longint'(lp_o), e_lp);
    chk({tag, " R2 ovf"}, longint'(ovf_o), e_ovf);
  endtask

  task automatic run_enc(input string tag, input longint des, input longint rf);
    launch(1'b0, des, rf, 0);
    wait_done();
    enc_model(des, rf);
    check_all(tag);
  endtask

  task automatic run_dec(input string tag, input longint w, input longint rf);
    launch(1'b1, 0, rf, w);
    wait_done();
    dec_model(w, rf);
    check_all(tag);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk("watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d2c_7b55));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset values
    chk("R10 busy", longint'(busy_o), 0);
    chk("R10 done", longint'(done_o), 0);
    chk("R10 word", longint'(word_o), 0);
    chk("R10 rate", longint'(rate_o), 0);
    chk("R10 lp", longint'(lp_o), 0);
    chk("R10 ovf", longint'(ovf_o), 0);

    // R1 divider search boundaries
    run_enc("R1 ref4999", 300000, 4999);
    chk("R1 div1", longint'(word_o[12:8]), 1);
    run_enc("R1 ref9999", 300000, 9999);
    chk("R1 div1b", longint'(word_o[12:8]), 1);
    run_enc("R1 ref10000", 300000, 10000);
    chk("R1 div2", longint'(word_o[12:8]), 2);
    run_enc("R1 clamp", 600000, 400000);
    chk("R1 div31", longint'(word_o[12:8]), 31);
    // R2 overflow
    run_enc("R2 sat", 3000000, 5000);
    chk("R2 ovf set", longint'(ovf_o), 1);
    // R3 band thresholds
    run_enc("R3 b3edge", 501000, 3000);
    chk("R3 band3", longint'(word_o[15:14]), 3);
    run_enc("R3 b3ceil", 500999, 3000);
    run_enc("R3 b2edge", 251000, 1000);
    chk("R3 band2", longint'(word_o[15:14]), 2);
    run_enc("R3 b1hi", 250000, 1000);
    chk("R3 band1hi", longint'(word_o[15:14]), 1);
    run_enc("R3 b1edge", 126000, 1000);
    chk("R3 band1", longint'(word_o[15:14]), 1);
    run_enc("R3 b0", 125000, 1000);
    chk("R3 band0", longint'(word_o[15:14]), 0);
    // R5 zero multiplier: band 0, rate uses multiplier 1
    run_enc("R5 zero", 0, 27000);
    chk("R3 zero band", longint'(word_o[15:14]), 0);
    run_enc("R5 zero big", 0, 4000000);
    // R6 low-power count wrap
    run_enc("R6 wrap", 8000000, 1000000);
    // R7 decode with zero fields and echo of bit 13
    run_dec("R7 zeros", 16'h0000, 27000);
    run_dec("R7 bit13", 16'hE0FF, 123456);
    run_dec("R7 div0", 16'h40A0, 50000);

    // R8 done width and start ignored while busy
    launch(1'b0, 700000, 26000, 0);
    repeat (10) @(negedge clk);
    decode_i = 1'b1; lane_kbps_i = 32'd1; ref_khz_i = 32'd999; word_i = 16'h1234;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_done();
    enc_model(700000, 26000);
    check_all("R8 ignore");
    @(negedge clk);
    chk("R8 done one cycle", longint'(done_o), 0);
    chk("R8 idle after", longint'(busy_o), 0);

    // R9 hold while idle with changing inputs
    lane_kbps_i = 32'd55555; ref_khz_i = 32'd77777; word_i = 16'hFFFF; decode_i = 1'b1;
    repeat (20) @(negedge clk);
    check_all("R9 hold");

    // random mix
    for (int i = 0; i < 120; i++) begin
      longint des, rf;
      des = longint'($urandom_range(1600000, 0));
      if ($urandom_range(3, 0) == 0) rf = longint'($urandom_range(2000000, 60000));
      else rf = longint'($urandom_range(60000, 1000));
      if ($urandom_range(4, 0) == 0) run_dec("R7 rnd", longint'($urandom_range(65535, 0)), rf);
      else run_enc("R1 R3 rnd", des, rf);
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule